// File: doc/BRIEF.md
# Interrupt Pin Delivery and End-of-Interrupt Engine

This block sits between a set of interrupt input lines and the fabric that carries interrupt messages to processor-local controllers. Each pin comes with its routing entry: a vector, a destination, a destination mode, a delivery mode, a trigger mode and a mask bit. The entries arrive as plain inputs, because register programming lives elsewhere. The block samples the lines into a request register with one bit per pin. It decides which pin is due for delivery and offers one message at a time on a valid/ready handshake. When several pins are due at once, the lowest-numbered one goes first.

Level-triggered pins follow a remote-IRR protocol. An accepted delivery sets the pin's remote-IRR bit, and an end-of-interrupt (EOI) broadcast that carries the pin's vector clears it. If the line is still asserted at that point, the pin is delivered again. Each pin counts its back-to-back EOI-driven re-deliveries. When the count reaches a storm threshold, the block holds the pin back and starts a shared deferral timer, so that a stuck line cannot flood the fabric. When the timer expires, every held level pin is released.

Edge-triggered pins are delivered once per rising edge of their request bit. A pin keeps a delivered flag, and the status output reports the request bits with the delivered edge pins removed.

Top module: `irq_route_engine`

## Requirements
- R1: The message outputs stay stable while `msg_valid` is high and `msg_ready` is low. Only one message is outstanding at a time. When several pins are due, the lowest-numbered pin is offered first, and each field is copied from that pin's entry.
- R2: An edge pin (trigger bit 0) that rises while unmasked is offered 2 cycles after the line goes high. Holding the line high does not produce another message. A new message needs the line to fall and then rise again.
- R3: A masked pin is never offered. An edge rise that occurs while the pin is masked is dropped and is not delivered after a later unmask. The pin's request bit is still recorded.
- R4: A level pin (trigger bit 1) is offered while its line is high, it is unmasked and its remote-IRR bit is clear. When the message is accepted, the pin's remote-IRR bit is set, and no further message is made for that pin while the bit is set.
- R5: Deasserting a line clears the pin's request bit on the next clock. A level pin whose line is low is not re-delivered by an EOI.
- R6: A non-directed EOI clears remote-IRR for every level pin whose vector equals the EOI vector. Pins with other vectors keep their remote-IRR bit. If the cleared pin is unmasked and still requested, it is offered again one cycle later.
- R7: While `directed_eoi` is high, an EOI leaves every remote-IRR bit unchanged.
- R8: Each pin counts consecutive EOI-driven re-deliveries. An EOI that finds the pin unrequested or masked resets the count to 0. When the count would reach `STORM_LIMIT`, the re-delivery is skipped, the count returns to 0, the pin is held back and the deferral timer starts.
- R9: The deferral timer expires `DEFER_CYCLES` cycles after it starts. Expiry releases the held pins, and each level pin that is then requested, unmasked and has remote-IRR clear is offered again.
- R10: `req_status` shows the request bits with the edge pins already delivered removed. A new rising edge on a pin clears its delivered flag.
- R11: After reset, `msg_valid`, `remote_irr` and `req_status` are 0, and all pin counters and the timer are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_line | input | NPINS | Interrupt line levels |
| ent_vector | input | NPINS*VEC_W | Vector of each pin, pin i at bits [i*VEC_W +: VEC_W] |
| ent_dest | input | NPINS*DEST_W | Destination of each pin |
| ent_dest_mode | input | NPINS | Destination mode bit of each pin |
| ent_deliv_mode | input | NPINS*3 | Delivery mode of each pin |
| ent_level | input | NPINS | Trigger mode: 1 level, 0 edge |
| ent_mask | input | NPINS | 1 masks the pin |
| eoi_valid | input | 1 | One-cycle EOI broadcast strobe |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| directed_eoi | input | 1 | 1 makes broadcast EOIs leave remote-IRR alone |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Destination accepts the message |
| msg_vector | output | VEC_W | Message vector |
| msg_dest | output | DEST_W | Message destination |
| msg_dest_mode | output | 1 | Message destination mode |
| msg_deliv_mode | output | 3 | Message delivery mode |
| msg_level | output | 1 | Message trigger mode |
| remote_irr | output | NPINS | Remote-IRR bits |
| req_status | output | NPINS | Request bits without the delivered edge pins |

## Verification
A line change is registered at the first clock edge, and `msg_valid` rises at the second edge, so the bench checks for a message two cycles after raising a line. It also checks one cycle earlier that no message has appeared yet. An accepted message clears `msg_valid` and sets `remote_irr` at that same edge. An EOI clears `remote_irr` at its own edge, and the re-delivered message follows one cycle later. For a storm, the bench counts exactly `DEFER_CYCLES` further edges with no message and then expects the message on the next edge. The bench drives inputs and samples outputs 1 ns after each rising edge, so every check falls at a fixed edge count.

// File: rtl/irqe_pkg.sv
package irqe_pkg;
  localparam int DMODE_W = 3;
  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;
endpackage

// File: rtl/irqe_pick.sv
module irqe_pick #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     want_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins (R1)
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (want_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |want_i;
endmodule

// File: rtl/irqe_defer.sv
module irqe_defer #(
  parameter int DEFER_CYCLES = 1000000,
  localparam int CW = $clog2(DEFER_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic expire_o
);
  logic          running_q;
  logic [CW-1:0] cnt_q;

  assign expire_o = running_q && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else if (running_q) begin
      if (cnt_q == CW'(1)) begin
        // a storm on the expiry cycle re-arms so its hold is not stranded
        running_q <= start_i;
        cnt_q     <= CW'(DEFER_CYCLES);
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end else if (start_i) begin
      running_q <= 1'b1;
      cnt_q     <= CW'(DEFER_CYCLES);
    end
  end

  p_start_runs_r8: assert property (@(posedge clk) disable iff (rst)
    start_i |=> running_q);
  p_expire_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (expire_o && !start_i) |=> !running_q);
endmodule

// File: rtl/irqe_pin.sv
module irqe_pin #(
  parameter int VEC_W = 8,
  parameter int STORM_LIMIT = 10000,
  localparam int CNT_W = $clog2(STORM_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_i,
  input  logic             level_mode_i,
  input  logic             mask_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             eoi_valid_i,
  input  logic [VEC_W-1:0] eoi_vec_i,
  input  logic             directed_i,
  input  logic             accept_i,
  input  logic             expire_i,
  output logic             want_o,
  output logic             req_o,
  output logic             rirr_o,
  output logic             deliv_o,
  output logic             storm_o
);
  logic             req_q, edge_pend_q, deliv_q, rirr_q, hold_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise, eoi_hit, redeliver;

  assign rise      = line_i & ~req_q;
  assign eoi_hit   = eoi_valid_i & ~directed_i & level_mode_i & (eoi_vec_i == vec_i);
  assign redeliver = eoi_hit & ~mask_i & req_q;
  assign storm_o   = redeliver & (cnt_q == CNT_W'(STORM_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q       <= 1'b0;
      edge_pend_q <= 1'b0;
      deliv_q     <= 1'b0;
      rirr_q      <= 1'b0;
      hold_q      <= 1'b0;
      cnt_q       <= '0;
    end else begin
      req_q <= line_i;                                    // R5
      // edge request: queued on a rise while unmasked (R2, R3)
      if (!level_mode_i && rise && !mask_i) edge_pend_q <= 1'b1;
      else if (accept_i || mask_i || level_mode_i) edge_pend_q <= 1'b0;
      // delivered edge flag (R10)
      if (rise) deliv_q <= 1'b0;
      else if (accept_i && !level_mode_i) deliv_q <= 1'b1;
      // remote-IRR (R4, R6, R7)
      if (accept_i && level_mode_i) rirr_q <= 1'b1;
      else if (eoi_hit) rirr_q <= 1'b0;
      // storm counter (R8)
      if (eoi_hit) cnt_q <= (redeliver && !storm_o) ? cnt_q + CNT_W'(1) : '0;
      if (storm_o) hold_q <= 1'b1;
      else if (expire_i) hold_q <= 1'b0;                  // R9
    end
  end

  assign want_o  = (edge_pend_q & ~mask_i & ~level_mode_i)
                 | (level_mode_i & req_q & ~rirr_q & ~mask_i & ~hold_q);
  assign req_o   = req_q;
  assign rirr_o  = rirr_q;
  assign deliv_o = deliv_q;

  p_accept_sets_rirr_r4: assert property (@(posedge clk) disable iff (rst)
    (accept_i && level_mode_i) |=> rirr_o);
  p_eoi_clears_rirr_r6: assert property (@(posedge clk) disable iff (rst)
    (eoi_hit && !accept_i) |=> !rirr_o);
  p_directed_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid_i && directed_i && !accept_i) |=> $stable(rirr_o));
  p_storm_holds_r8: assert property (@(posedge clk) disable iff (rst)
    storm_o |=> (hold_q && cnt_q == '0));
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import irqe_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int VEC_W = 8,
  parameter int DEST_W = 8,
  parameter int STORM_LIMIT = 10000,
  parameter int DEFER_CYCLES = 1000000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPINS-1:0]        pin_line,
  input  logic [NPINS*VEC_W-1:0]  ent_vector,
  input  logic [NPINS*DEST_W-1:0] ent_dest,
  input  logic [NPINS-1:0]        ent_dest_mode,
  input  logic [NPINS*3-1:0]      ent_deliv_mode,
  input  logic [NPINS-1:0]        ent_level,
  input  logic [NPINS-1:0]        ent_mask,
  input  logic                    eoi_valid,
  input  logic [VEC_W-1:0]        eoi_vector,
  input  logic                    directed_eoi,
  output logic                    msg_valid,
  input  logic                    msg_ready,
  output logic [VEC_W-1:0]        msg_vector,
  output logic [DEST_W-1:0]       msg_dest,
  output logic                    msg_dest_mode,
  output logic [2:0]              msg_deliv_mode,
  output logic                    msg_level,
  output logic [NPINS-1:0]        remote_irr,
  output logic [NPINS-1:0]        req_status
);
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;

  logic [NPINS-1:0] want, req, rirr, deliv, storm, accept_vec;
  logic             pick_any, expire;
  logic [IDX_W-1:0] pick_idx, sel_q;

  logic                 msg_valid_q, msg_dest_mode_q;
  logic [VEC_W-1:0]     msg_vector_q;
  logic [DEST_W-1:0]    msg_dest_q;
  logic [DMODE_W-1:0]   msg_deliv_mode_q;
  trig_e                msg_trig_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign accept_vec[i] = msg_valid_q & msg_ready & (sel_q == IDX_W'(i));
    irqe_pin #(.VEC_W(VEC_W), .STORM_LIMIT(STORM_LIMIT)) u_pin (
      .clk          (clk),
      .rst          (rst),
      .line_i       (pin_line[i]),
      .level_mode_i (ent_level[i]),
      .mask_i       (ent_mask[i]),
      .vec_i        (ent_vector[i*VEC_W +: VEC_W]),
      .eoi_valid_i  (eoi_valid),
      .eoi_vec_i    (eoi_vector),
      .directed_i   (directed_eoi),
      .accept_i     (accept_vec[i]),
      .expire_i     (expire),
      .want_o       (want[i]),
      .req_o        (req[i]),
      .rirr_o       (rirr[i]),
      .deliv_o      (deliv[i]),
      .storm_o      (storm[i])
    );
  end

  irqe_pick #(.N(NPINS)) u_pick (
    .want_i (want),
    .any_o  (pick_any),
    .idx_o  (pick_idx)
  );

  irqe_defer #(.DEFER_CYCLES(DEFER_CYCLES)) u_defer (
    .clk      (clk),
    .rst      (rst),
    .start_i  (|storm),
    .expire_o (expire)
  );

  // single outstanding message register (R1)
  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid_q      <= 1'b0;
      sel_q            <= '0;
      msg_vector_q     <= '0;
      msg_dest_q       <= '0;
      msg_dest_mode_q  <= 1'b0;
      msg_deliv_mode_q <= '0;
      msg_trig_q       <= TRIG_EDGE;
    end else if (msg_valid_q) begin
      if (msg_ready) msg_valid_q <= 1'b0;
    end else if (pick_any) begin
      msg_valid_q      <= 1'b1;
      sel_q            <= pick_idx;
      msg_vector_q     <= ent_vector[pick_idx*VEC_W +: VEC_W];
      msg_dest_q       <= ent_dest[pick_idx*DEST_W +: DEST_W];
      msg_dest_mode_q  <= ent_dest_mode[pick_idx];
      msg_deliv_mode_q <= ent_deliv_mode[pick_idx*DMODE_W +: DMODE_W];
      msg_trig_q       <= trig_e'(ent_level[pick_idx]);
    end
  end

  assign msg_valid      = msg_valid_q;
  assign msg_vector     = msg_vector_q;
  assign msg_dest       = msg_dest_q;
  assign msg_dest_mode  = msg_dest_mode_q;
  assign msg_deliv_mode = msg_deliv_mode_q;
  assign msg_level      = (msg_trig_q == TRIG_LEVEL);
  assign remote_irr     = rirr;
  assign req_status     = req & ~deliv;                   // R10

  p_msg_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector)
      && $stable(msg_dest) && $stable(msg_deliv_mode) && $stable(msg_level)));
  p_one_accept_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(accept_vec));
endmodule

// File: tb/tb_irq_route_engine.sv
module tb_irq_route_engine;
  localparam int NP = 4, VW = 8, DW = 8, LIM = 3, DEF = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NP-1:0]    line = '0, lvl = '0, msk = '1, dmd;
  logic [NP*VW-1:0] vecs;
  logic [NP*DW-1:0] dsts;
  logic [NP*3-1:0]  dms;
  logic             eoi_v = 1'b0, dir = 1'b0, rdy = 1'b0;
  logic [VW-1:0]    eoi_vec = '0;
  logic             mv, mdm, mlvl;
  logic [VW-1:0]    mvec;
  logic [DW-1:0]    mdst;
  logic [2:0]       mdmode;
  logic [NP-1:0]    rirr, stat;

  int  checks = 0, errors = 0;
  bit  done = 1'b0;

  irq_route_engine #(.NPINS(NP), .VEC_W(VW), .DEST_W(DW),
                     .STORM_LIMIT(LIM), .DEFER_CYCLES(DEF)) dut (
    .clk(clk), .rst(rst), .pin_line(line), .ent_vector(vecs), .ent_dest(dsts),
    .ent_dest_mode(dmd), .ent_deliv_mode(dms), .ent_level(lvl), .ent_mask(msk),
    .eoi_valid(eoi_v), .eoi_vector(eoi_vec), .directed_eoi(dir),
    .msg_valid(mv), .msg_ready(rdy), .msg_vector(mvec), .msg_dest(mdst),
    .msg_dest_mode(mdm), .msg_deliv_mode(mdmode), .msg_level(mlvl),
    .remote_irr(rirr), .req_status(stat)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic take;
    rdy = 1'b1;
    tick();
    rdy = 1'b0;
  endtask

  task automatic eoi(input logic [VW-1:0] v);
    eoi_v = 1'b1;
    eoi_vec = v;
    tick();
    eoi_v = 1'b0;
  endtask

  // one EOI-driven re-delivery of pin 0
  task automatic redo(input string tag);
    eoi(8'h30);
    chk(tag, "rirr cleared by eoi", rirr[0], 1'b0);
    chk(tag, "no msg in eoi cycle", mv, 1'b0);
    tick();
    chk(tag, "redelivered valid", mv, 1'b1);
    chk(tag, "redelivered vector", mvec, 8'h30);
    take();
    chk(tag, "rirr set again", rirr[0], 1'b1);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      vecs[i*VW +: VW] = 8'(8'h30 + i);
      dsts[i*DW +: DW] = 8'(8'h10 + i);
      dmd[i]           = i[0];
      dms[i*3 +: 3]    = 3'(i);
    end
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R11", "msg_valid after reset", mv, 1'b0);
    chk("R11", "remote_irr after reset", rirr, '0);
    chk("R11", "req_status after reset", stat, '0);

    // R2 / R1 / R10: edge pin 0
    msk[0] = 1'b0;
    line[0] = 1'b1;
    tick();
    chk("R2", "no msg one cycle after rise", mv, 1'b0);
    chk("R10", "status shows undelivered edge", stat[0], 1'b1);
    tick();
    chk("R2", "msg two cycles after rise", mv, 1'b1);
    chk("R1", "vector", mvec, 8'h30);
    chk("R1", "dest", mdst, 8'h10);
    chk("R1", "dest mode", mdm, 1'b0);
    chk("R1", "delivery mode", mdmode, 3'd0);
    chk("R1", "trigger edge", mlvl, 1'b0);
    repeat (3) tick();
    chk("R1", "held while not ready", mv, 1'b1);
    chk("R1", "vector held", mvec, 8'h30);
    take();
    chk("R1", "valid drops on accept", mv, 1'b0);
    chk("R10", "delivered edge removed", stat[0], 1'b0);
    repeat (4) tick();
    chk("R2", "high line coalesced", mv, 1'b0);
    line[0] = 1'b0;
    tick();
    line[0] = 1'b1;
    tick();
    tick();
    chk("R2", "new rise redelivers", mv, 1'b1);
    take();
    line[0] = 1'b0;
    tick();

    // R3: masked edge pin 1
    line[1] = 1'b1;
    repeat (3) tick();
    chk("R3", "masked pin silent", mv, 1'b0);
    chk("R3", "masked request tracked", stat[1], 1'b1);
    msk[1] = 1'b0;
    repeat (3) tick();
    chk("R3", "masked rise dropped", mv, 1'b0);
    line[1] = 1'b0;
    msk[1] = 1'b1;
    tick();

    // R1: priority between pins 2 and 3
    msk[3:2] = 2'b00;
    line[3:2] = 2'b11;
    tick();
    tick();
    chk("R1", "lowest pin first", mvec, 8'h32);
    chk("R1", "pin2 delivery mode", mdmode, 3'd2);
    take();
    chk("R1", "gap after accept", mv, 1'b0);
    tick();
    chk("R1", "second pin offered", mv, 1'b1);
    chk("R1", "second vector", mvec, 8'h33);
    chk("R1", "second dest", mdst, 8'h13);
    chk("R1", "second dest mode", mdm, 1'b1);
    take();
    line[3:2] = 2'b00;
    msk[3:2] = 2'b11;
    tick();

    // R4: level pin 0
    lvl[0] = 1'b1;
    line[0] = 1'b1;
    tick();
    tick();
    chk("R4", "level msg", mv, 1'b1);
    chk("R4", "level trigger", mlvl, 1'b1);
    take();
    chk("R4", "rirr set on accept", rirr[0], 1'b1);
    repeat (3) tick();
    chk("R4", "blocked by rirr", mv, 1'b0);

    // R6: other vector, R7: directed
    eoi(8'h31);
    chk("R6", "other vector keeps rirr", rirr[0], 1'b1);
    dir = 1'b1;
    eoi(8'h30);
    dir = 1'b0;
    chk("R7", "directed eoi keeps rirr", rirr[0], 1'b1);
    tick();
    chk("R7", "no msg after directed eoi", mv, 1'b0);

    // R6 / R8 / R5 / R9
    redo("R6");
    redo("R8");
    line[0] = 1'b0;
    tick();
    chk("R5", "line low clears request", stat[0], 1'b0);
    eoi(8'h30);
    chk("R5", "rirr cleared", rirr[0], 1'b0);
    repeat (3) tick();
    chk("R5", "no redelivery with line low", mv, 1'b0);
    line[0] = 1'b1;
    tick();
    tick();
    chk("R4", "fresh level delivery", mv, 1'b1);
    take();
    redo("R8 count reset");
    redo("R8 count reset");
    eoi(8'h30);
    chk("R8", "storm eoi clears rirr", rirr[0], 1'b0);
    repeat (DEF) tick();
    chk("R8", "redelivery deferred", mv, 1'b0);
    tick();
    chk("R9", "released at expiry", mv, 1'b1);
    chk("R9", "released vector", mvec, 8'h30);
    take();
    chk("R9", "rirr after released accept", rirr[0], 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule